// File: doc/BRIEF.md
# Multi-Page-Size Translation Lookaside Buffer

This block translates 32-bit effective addresses into 32-bit physical addresses for a single access stream (instruction fetch or data). It keeps a small table of entries that are all compared at once on each lookup. Each entry maps a 4 KB, 16 KB, 512 KB or 8 MB page. A 4 KB entry may also enable 1 KB subpage validity. Entries are tagged with an address-space identifier, which can be overridden by a shared flag. Each entry carries a protection-group number and attribute bits for no-execute, guarded and changed.

A lookup is presented with the effective address, the current address-space identifier, the access kind and a translation-enable bit. One clock later the block returns a registered response: the physical address, the hit, miss and multi-hit flags, the protection group of the matching entry, and two fault flags. One fault refuses fetches from no-execute or guarded pages. The other reports the first store to a page whose changed bit is clear. No reference bit is kept. The core owns table walking and exception handling. Software fills the table through a load port, with either an explicit index or a round-robin victim index. It can drop a single entry or clear the whole table.

Top module: `pageXlateTlb`

## Requirements
- R1: The table holds 32 entries, and a lookup compares against all of them in the same cycle, so an entry written at any index (0 through 31) can hit.
- R2: Page-size code 0 selects 4 KB, 1 selects 16 KB, 2 selects 512 KB and 3 selects 8 MB. The entry's tag is compared on address bits 31 down to 12, 14, 19 or 23 respectively. The physical address takes the upper bits from the entry and the page-offset bits from the effective address.
- R3: A 4 KB entry with subpage enable set hits only if bit N of its 4-bit subpage mask is set, where N is effective-address bits [11:10].
- R4: With translation disabled, the physical address equals the effective address, and the hit, miss, fault and multi-hit flags all stay low. The held miss address does not change.
- R5: An entry hits only when its address-space identifier equals the lookup's 4-bit identifier, or when its shared flag is set.
- R6: On a hit, the entry's 4-bit protection group appears on the group output.
- R7: Access kinds are 0 load, 1 store and 2 fetch. A fetch that hits an entry marked no-execute or guarded raises the fetch fault and returns physical address 0. A load that hits the same entry is translated normally.
- R8: A store that hits an entry whose changed bit is clear raises the change fault and returns physical address 0. A load hitting that entry, or a store hitting an entry whose changed bit is set, is translated without a fault.
- R9: A translated lookup that matches no entry gives a one-cycle miss pulse and physical address 0. In the same cycle, the held miss address takes that lookup's effective address.
- R10: The victim index is 0 after reset. It steps by one after each load that uses it, wrapping from 31 back to 0. Loads with an explicit index leave it unchanged.
- R11: A single invalidate clears the entry at the given index, and a full invalidate clears every entry. When several operations arrive in the same cycle, the full invalidate wins over the single invalidate, and the single invalidate wins over a load.
- R12: When several entries match, the lowest-indexed one supplies the translation and the multi-hit flag is raised.
- R13: The response is valid exactly one clock after a lookup is presented. In cycles without a response, hit and miss are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request |
| lkAddr | input | 32 | Effective address |
| lkAsid | input | 4 | Current address-space identifier |
| lkKind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| xlateEn | input | 1 | Translation enable for this stream |
| wrEn | input | 1 | Load an entry |
| wrUseVictim | input | 1 | Use the round-robin victim index instead of wrIndex |
| wrIndex | input | 5 | Explicit load index |
| wrVpn | input | 20 | Effective page tag (address bits 31:12) |
| wrPsize | input | 2 | Page-size code |
| wrSubEn | input | 1 | Enable 1 KB subpage checking (4 KB pages) |
| wrSubValid | input | 4 | Subpage valid mask |
| wrAsid | input | 4 | Entry address-space identifier |
| wrShared | input | 1 | Entry matches every address space |
| wrGroup | input | 4 | Protection group |
| wrNoExec | input | 1 | No-execute attribute |
| wrGuarded | input | 1 | Guarded attribute |
| wrChanged | input | 1 | Changed attribute |
| wrPpn | input | 20 | Physical page (address bits 31:12) |
| invOne | input | 1 | Invalidate one entry |
| invIndex | input | 5 | Index to invalidate |
| invAll | input | 1 | Invalidate all entries |
| victimIdx | output | 5 | Current round-robin victim index |
| rspValid | output | 1 | Response valid |
| rspHit | output | 1 | Lookup matched an entry |
| rspMiss | output | 1 | Translated lookup matched no entry |
| rspPaddr | output | 32 | Physical address |
| rspGroup | output | 4 | Protection group of the selected entry |
| rspFetchFault | output | 1 | Fetch refused by no-execute or guarded |
| rspChangeFault | output | 1 | Store to a page whose changed bit is clear |
| rspMultiHit | output | 1 | More than one entry matched |
| missAddr | output | 32 | Effective address of the latest miss |

## Verification
The response to a lookup presented before a rising edge is registered at that edge. The victim index, the held miss address and the table contents also change at that same edge. The bench therefore drives every input on the falling edge and reads each result on the following falling edge, one full cycle after the stimulus. Its behavioural model advances on the same rising edge, using the inputs as they stood before that edge. A write and a lookup in the same cycle therefore give the lookup the old table contents, in the model as in the design. Directed lookups also check literal expected values at that falling edge.

// File: rtl/tlbPkg.sv
package tlbPkg;
  localparam int ADDR_W = 32;
  localparam int PAGE_LSB = 12;
  localparam int VPN_W = ADDR_W - PAGE_LSB;
  localparam int ASID_W = 4;
  localparam int GRP_W = 4;
  localparam int SUB_N = 4;

  typedef enum logic [1:0] {PS_4K = 2'd0, PS_16K = 2'd1, PS_512K = 2'd2, PS_8M = 2'd3} pageSizeT;
  typedef enum logic [1:0] {ACC_LOAD = 2'd0, ACC_STORE = 2'd1, ACC_FETCH = 2'd2, ACC_RSVD = 2'd3} accKindT;

  typedef struct packed {
    logic              valid;
    logic [VPN_W-1:0]  vpn;
    pageSizeT          psize;
    logic              subEn;
    logic [SUB_N-1:0]  subValid;
    logic [ASID_W-1:0] asid;
    logic              shared;
    logic [GRP_W-1:0]  group;
    logic              noExec;
    logic              guarded;
    logic              changed;
    logic [VPN_W-1:0]  ppn;
  } entryT;

  typedef struct packed {
    logic doWrite;
    logic doInvOne;
    logic doInvAll;
  } ctlStrobeT;

  function automatic logic [VPN_W-1:0] pageMask(pageSizeT ps);
    logic [VPN_W-1:0] m;
    m = '1;
    case (ps)
      PS_16K:  m = m << 2;
      PS_512K: m = m << 7;
      PS_8M:   m = m << 11;
      default: m = '1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/tlbControl.sv
module tlbControl
  import tlbPkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrUseVictim,
  input  logic [IDX_W-1:0]  wrIndex,
  input  logic              invOne,
  input  logic              invAll,
  input  logic              lkValid,
  input  logic              xlateEn,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic              lookMiss,
  output ctlStrobeT         strobe,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [IDX_W-1:0]  victimIdx,
  output logic [ADDR_W-1:0] missAddr
);
  logic [IDX_W-1:0] victimQ;
  logic             victimStep;

  // one maintenance operation per cycle: full clear, then single, then load
  always_comb begin
    strobe.doInvAll = invAll;
    strobe.doInvOne = invOne && !invAll;
    strobe.doWrite  = wrEn && !invOne && !invAll;
  end

  assign victimStep = strobe.doWrite && wrUseVictim;
  assign wrIdx      = wrUseVictim ? victimQ : wrIndex;
  assign victimIdx  = victimQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      victimQ <= '0;
    end else if (victimStep) begin
      victimQ <= (victimQ == IDX_W'(ENTRIES - 1)) ? '0 : victimQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      missAddr <= '0;
    end else if (lkValid && xlateEn && lookMiss) begin
      missAddr <= lkAddr;
    end
  end
endmodule

// File: rtl/tlbDatapath.sv
module tlbDatapath
  import tlbPkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         strobe,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [IDX_W-1:0]  invIdx,
  input  entryT             wrEntry,
  input  logic              lkValid,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic [1:0]        lkKind,
  input  logic              xlateEn,
  output logic              lookMiss,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspMiss,
  output logic [ADDR_W-1:0] rspPaddr,
  output logic [GRP_W-1:0]  rspGroup,
  output logic              rspFetchFault,
  output logic              rspChangeFault,
  output logic              rspMultiHit
);
  entryT            tab [ENTRIES];
  logic [ENTRIES-1:0] matchVec;
  logic [IDX_W-1:0] selIdx;
  entryT            sel;
  logic [VPN_W-1:0] selMask;
  logic             anyHit, multiHit, fetchBad, storeBad;
  logic [ADDR_W-1:0] xlatedAddr;
  accKindT          kind;
  logic [VPN_W-1:0] lkVpn;
  logic [1:0]       subSel;

  assign lkVpn  = lkAddr[ADDR_W-1:PAGE_LSB];
  assign subSel = lkAddr[PAGE_LSB-1:PAGE_LSB-2];
  assign kind   = accKindT'(lkKind);

  // table storage and maintenance
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) tab[i] <= '0;
    end else if (strobe.doInvAll) begin
      for (int i = 0; i < ENTRIES; i++) tab[i].valid <= 1'b0;
    end else if (strobe.doInvOne) begin
      tab[invIdx].valid <= 1'b0;
    end else if (strobe.doWrite) begin
      tab[wrIdx]       <= wrEntry;
      tab[wrIdx].valid <= 1'b1;
    end
  end

  // parallel compare, one comparator per entry
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    logic [VPN_W-1:0] msk;
    logic tagOk, asidOk, subOk;
    assign msk    = pageMask(tab[e].psize);
    assign tagOk  = ((lkVpn ^ tab[e].vpn) & msk) == '0;
    assign asidOk = tab[e].shared || (tab[e].asid == lkAsid);
    assign subOk  = !(tab[e].psize == PS_4K && tab[e].subEn) || tab[e].subValid[subSel];
    assign matchVec[e] = tab[e].valid && tagOk && asidOk && subOk;
  end

  // lowest index wins
  always_comb begin
    selIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) selIdx = IDX_W'(i);
    end
  end

  assign sel        = tab[selIdx];
  assign selMask    = pageMask(sel.psize);
  assign anyHit     = |matchVec;
  assign multiHit   = (matchVec & (matchVec - 1'b1)) != '0;
  assign lookMiss   = !anyHit;
  assign fetchBad   = anyHit && (kind == ACC_FETCH) && (sel.noExec || sel.guarded);
  assign storeBad   = anyHit && (kind == ACC_STORE) && !sel.changed;
  assign xlatedAddr = {(sel.ppn & selMask) | (lkVpn & ~selMask), lkAddr[PAGE_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid       <= 1'b0;
      rspHit         <= 1'b0;
      rspMiss        <= 1'b0;
      rspPaddr       <= '0;
      rspGroup       <= '0;
      rspFetchFault  <= 1'b0;
      rspChangeFault <= 1'b0;
      rspMultiHit    <= 1'b0;
    end else begin
      rspValid       <= lkValid;
      rspHit         <= 1'b0;
      rspMiss        <= 1'b0;
      rspPaddr       <= '0;
      rspGroup       <= '0;
      rspFetchFault  <= 1'b0;
      rspChangeFault <= 1'b0;
      rspMultiHit    <= 1'b0;
      if (lkValid && !xlateEn) begin
        rspPaddr <= lkAddr;
      end else if (lkValid && anyHit) begin
        rspHit         <= 1'b1;
        rspGroup       <= sel.group;
        rspMultiHit    <= multiHit;
        rspFetchFault  <= fetchBad;
        rspChangeFault <= storeBad;
        rspPaddr       <= (fetchBad || storeBad) ? '0 : xlatedAddr;
      end else if (lkValid) begin
        rspMiss <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pageXlateTlb.sv
module pageXlateTlb
  import tlbPkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [31:0]       lkAddr,
  input  logic [3:0]        lkAsid,
  input  logic [1:0]        lkKind,
  input  logic              xlateEn,
  input  logic              wrEn,
  input  logic              wrUseVictim,
  input  logic [IDX_W-1:0]  wrIndex,
  input  logic [19:0]       wrVpn,
  input  logic [1:0]        wrPsize,
  input  logic              wrSubEn,
  input  logic [3:0]        wrSubValid,
  input  logic [3:0]        wrAsid,
  input  logic              wrShared,
  input  logic [3:0]        wrGroup,
  input  logic              wrNoExec,
  input  logic              wrGuarded,
  input  logic              wrChanged,
  input  logic [19:0]       wrPpn,
  input  logic              invOne,
  input  logic [IDX_W-1:0]  invIndex,
  input  logic              invAll,
  output logic [IDX_W-1:0]  victimIdx,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspMiss,
  output logic [31:0]       rspPaddr,
  output logic [3:0]        rspGroup,
  output logic              rspFetchFault,
  output logic              rspChangeFault,
  output logic              rspMultiHit,
  output logic [31:0]       missAddr
);
  ctlStrobeT        strobe;
  logic [IDX_W-1:0] wrIdx;
  logic             lookMiss;
  entryT            wrEntry;

  always_comb begin
    wrEntry.valid    = 1'b1;
    wrEntry.vpn      = wrVpn;
    wrEntry.psize    = pageSizeT'(wrPsize);
    wrEntry.subEn    = wrSubEn;
    wrEntry.subValid = wrSubValid;
    wrEntry.asid     = wrAsid;
    wrEntry.shared   = wrShared;
    wrEntry.group    = wrGroup;
    wrEntry.noExec   = wrNoExec;
    wrEntry.guarded  = wrGuarded;
    wrEntry.changed  = wrChanged;
    wrEntry.ppn      = wrPpn;
  end

  tlbControl #(.ENTRIES(ENTRIES)) u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrUseVictim(wrUseVictim),
    .wrIndex(wrIndex), .invOne(invOne), .invAll(invAll),
    .lkValid(lkValid), .xlateEn(xlateEn), .lkAddr(lkAddr),
    .lookMiss(lookMiss), .strobe(strobe), .wrIdx(wrIdx),
    .victimIdx(victimIdx), .missAddr(missAddr)
  );

  tlbDatapath #(.ENTRIES(ENTRIES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx),
    .invIdx(invIndex), .wrEntry(wrEntry), .lkValid(lkValid),
    .lkAddr(lkAddr), .lkAsid(lkAsid), .lkKind(lkKind), .xlateEn(xlateEn),
    .lookMiss(lookMiss), .rspValid(rspValid), .rspHit(rspHit),
    .rspMiss(rspMiss), .rspPaddr(rspPaddr), .rspGroup(rspGroup),
    .rspFetchFault(rspFetchFault), .rspChangeFault(rspChangeFault),
    .rspMultiHit(rspMultiHit)
  );
endmodule

// File: rtl/tlbChecker.sv
module tlbChecker #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             lkValid,
  input logic [31:0]      lkAddr,
  input logic [1:0]       lkKind,
  input logic             xlateEn,
  input logic             wrEn,
  input logic             wrUseVictim,
  input logic             invOne,
  input logic             invAll,
  input logic [IDX_W-1:0] victimIdx,
  input logic             rspValid,
  input logic             rspHit,
  input logic             rspMiss,
  input logic [31:0]      rspPaddr,
  input logic             rspFetchFault,
  input logic             rspChangeFault,
  input logic             rspMultiHit,
  input logic [31:0]      missAddr
);
  p_latency_r13: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (rspValid == $past(lkValid)));

  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!rspHit && !rspMiss));

  p_bypass_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(lkValid && !xlateEn)) |->
      (rspPaddr == $past(lkAddr) && !rspHit && !rspMiss && !rspFetchFault && !rspChangeFault));

  p_miss_alone_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspMiss |-> (!rspHit && !rspFetchFault && !rspChangeFault && !rspMultiHit));

  p_miss_capture_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && rspMiss) |-> (missAddr == $past(lkAddr)));

  p_fetch_fault_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && rspFetchFault) |-> (rspHit && rspPaddr == 32'd0 && $past(lkKind) == 2'd2));

  p_change_fault_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && rspChangeFault) |-> (rspHit && rspPaddr == 32'd0 && $past(lkKind) == 2'd1));

  p_multi_needs_hit_r12: assert property (@(posedge clk) disable iff (!rstN)
    rspMultiHit |-> rspHit);

  p_victim_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wrEn && wrUseVictim && !invOne && !invAll)) |->
      (victimIdx != $past(victimIdx)));

  p_victim_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(wrEn && wrUseVictim)) |-> $stable(victimIdx));
endmodule

bind pageXlateTlb tlbChecker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkAddr(lkAddr),
  .lkKind(lkKind), .xlateEn(xlateEn), .wrEn(wrEn),
  .wrUseVictim(wrUseVictim), .invOne(invOne), .invAll(invAll),
  .victimIdx(victimIdx), .rspValid(rspValid), .rspHit(rspHit),
  .rspMiss(rspMiss), .rspPaddr(rspPaddr), .rspFetchFault(rspFetchFault),
  .rspChangeFault(rspChangeFault), .rspMultiHit(rspMultiHit),
  .missAddr(missAddr)
);

// File: tb/tb_pageXlateTlb.sv
`timescale 1ns/1ps
module tb_pageXlateTlb;
  logic clk = 0, rstN = 0;
  logic lkValid = 0, xlateEn = 0;
  logic [31:0] lkAddr = 0;
  logic [3:0] lkAsid = 0;
  logic [1:0] lkKind = 0;
  logic wrEn = 0, wrUseVictim = 0, wrSubEn = 0, wrShared = 0;
  logic wrNoExec = 0, wrGuarded = 0, wrChanged = 0;
  logic [4:0] wrIndex = 0, invIndex = 0;
  logic [19:0] wrVpn = 0, wrPpn = 0;
  logic [1:0] wrPsize = 0;
  logic [3:0] wrSubValid = 0, wrAsid = 0, wrGroup = 0;
  logic invOne = 0, invAll = 0;
  logic [4:0] victimIdx;
  logic rspValid, rspHit, rspMiss, rspFetchFault, rspChangeFault, rspMultiHit;
  logic [31:0] rspPaddr, missAddr;
  logic [3:0] rspGroup;

  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pageXlateTlb dut (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkAddr(lkAddr), .lkAsid(lkAsid),
    .lkKind(lkKind), .xlateEn(xlateEn), .wrEn(wrEn), .wrUseVictim(wrUseVictim),
    .wrIndex(wrIndex), .wrVpn(wrVpn), .wrPsize(wrPsize), .wrSubEn(wrSubEn),
    .wrSubValid(wrSubValid), .wrAsid(wrAsid), .wrShared(wrShared), .wrGroup(wrGroup),
    .wrNoExec(wrNoExec), .wrGuarded(wrGuarded), .wrChanged(wrChanged), .wrPpn(wrPpn),
    .invOne(invOne), .invIndex(invIndex), .invAll(invAll), .victimIdx(victimIdx),
    .rspValid(rspValid), .rspHit(rspHit), .rspMiss(rspMiss), .rspPaddr(rspPaddr),
    .rspGroup(rspGroup), .rspFetchFault(rspFetchFault), .rspChangeFault(rspChangeFault),
    .rspMultiHit(rspMultiHit), .missAddr(missAddr)
  );

  // behavioural reference table
  bit mV[32], mSubEn[32], mSh[32], mNx[32], mGd[32], mCh[32];
  logic [31:0] mVa[32], mPa[32];
  int mPs[32];
  logic [3:0] mSub[32], mAsid[32], mGrp[32];
  int mVictim;
  logic [31:0] mMissA;
  bit eValid, eHit, eMiss, eFf, eCf, eMulti;
  logic [31:0] ePaddr;
  logic [3:0] eGrp;

  function automatic int shiftOf(int ps);
    case (ps)
      0: return 12;
      1: return 14;
      2: return 19;
      default: return 23;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 32; i++) mV[i] = 0;
      mVictim = 0; mMissA = 0;
      eValid = 0; eHit = 0; eMiss = 0; eFf = 0; eCf = 0; eMulti = 0; ePaddr = 0; eGrp = 0;
    end else begin
      eValid = lkValid; eHit = 0; eMiss = 0; eFf = 0; eCf = 0; eMulti = 0; ePaddr = 0; eGrp = 0;
      if (lkValid && !xlateEn) ePaddr = lkAddr;
      else if (lkValid) begin
        int first, cnt;
        first = -1; cnt = 0;
        for (int i = 0; i < 32; i++) begin
          int sh;
          bit ok;
          sh = shiftOf(mPs[i]);
          ok = mV[i] && ((lkAddr >> sh) == (mVa[i] >> sh)) && (mSh[i] || mAsid[i] == lkAsid)
               && !(mPs[i] == 0 && mSubEn[i] && !mSub[i][lkAddr[11:10]]);
          if (ok) begin cnt++; if (first < 0) first = i; end
        end
        if (first < 0) begin eMiss = 1; mMissA = lkAddr; end
        else begin
          logic [31:0] m;
          m = 32'hFFFF_FFFF << shiftOf(mPs[first]);
          eHit = 1; eGrp = mGrp[first]; eMulti = (cnt > 1);
          eFf = (lkKind == 2) && (mNx[first] || mGd[first]);
          eCf = (lkKind == 1) && !mCh[first];
          ePaddr = (eFf || eCf) ? 32'd0 : ((mPa[first] & m) | (lkAddr & ~m));
        end
      end
      if (invAll) for (int i = 0; i < 32; i++) mV[i] = 0;
      else if (invOne) mV[invIndex] = 0;
      else if (wrEn) begin
        int k;
        k = wrUseVictim ? mVictim : int'(wrIndex);
        if (wrUseVictim) mVictim = (mVictim + 1) % 32;
        mV[k] = 1; mVa[k] = {wrVpn, 12'd0}; mPa[k] = {wrPpn, 12'd0}; mPs[k] = int'(wrPsize);
        mSubEn[k] = wrSubEn; mSub[k] = wrSubValid; mAsid[k] = wrAsid; mSh[k] = wrShared;
        mGrp[k] = wrGroup; mNx[k] = wrNoExec; mGd[k] = wrGuarded; mCh[k] = wrChanged;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      bit bad;
      bad = 0;
      tests++;
      if (rspValid !== eValid) begin bad = 1; $display("FAIL R13 valid got %0b exp %0b", rspValid, eValid); end
      if (rspHit !== eHit) begin bad = 1; $display("FAIL R1 hit got %0b exp %0b", rspHit, eHit); end
      if (rspMiss !== eMiss) begin bad = 1; $display("FAIL R9 miss got %0b exp %0b", rspMiss, eMiss); end
      if (rspPaddr !== ePaddr) begin bad = 1; $display("FAIL R2 paddr got %h exp %h", rspPaddr, ePaddr); end
      if (rspGroup !== eGrp) begin bad = 1; $display("FAIL R6 group got %h exp %h", rspGroup, eGrp); end
      if (rspFetchFault !== eFf) begin bad = 1; $display("FAIL R7 fetch fault got %0b exp %0b", rspFetchFault, eFf); end
      if (rspChangeFault !== eCf) begin bad = 1; $display("FAIL R8 change fault got %0b exp %0b", rspChangeFault, eCf); end
      if (rspMultiHit !== eMulti) begin bad = 1; $display("FAIL R12 multi got %0b exp %0b", rspMultiHit, eMulti); end
      if (missAddr !== mMissA) begin bad = 1; $display("FAIL R9 missAddr got %h exp %h", missAddr, mMissA); end
      if (int'(victimIdx) != mVictim) begin bad = 1; $display("FAIL R10 victim got %0d exp %0d", victimIdx, mVictim); end
      if (bad) fails++;
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(input bit vic, input int idx, input logic [19:0] vpn, input int ps,
                    input bit sen, input logic [3:0] sub, input logic [3:0] asid, input bit sh,
                    input logic [3:0] grp, input bit nx, input bit gd, input bit ch,
                    input logic [19:0] ppn);
    @(negedge clk);
    wrEn = 1; wrUseVictim = vic; wrIndex = 5'(idx); wrVpn = vpn; wrPsize = 2'(ps);
    wrSubEn = sen; wrSubValid = sub; wrAsid = asid; wrShared = sh; wrGroup = grp;
    wrNoExec = nx; wrGuarded = gd; wrChanged = ch; wrPpn = ppn;
    @(negedge clk);
    wrEn = 0; wrUseVictim = 0;
  endtask

  // drive at a falling edge, result checked on the next falling edge
  task automatic look(input string req, input logic [31:0] a, input logic [3:0] asid,
                      input int kind, input bit en, input bit xHit, input bit xMiss,
                      input logic [31:0] xPa, input bit xFf, input bit xCf);
    @(negedge clk);
    lkValid = 1; lkAddr = a; lkAsid = asid; lkKind = 2'(kind); xlateEn = en;
    @(negedge clk);
    lkValid = 0;
    tests++;
    if (rspHit !== xHit || rspMiss !== xMiss || rspPaddr !== xPa ||
        rspFetchFault !== xFf || rspChangeFault !== xCf) begin
      fails++;
      $display("FAIL %s hit/miss/pa/ff/cf got %0b/%0b/%h/%0b/%0b exp %0b/%0b/%h/%0b/%0b",
               req, rspHit, rspMiss, rspPaddr, rspFetchFault, rspChangeFault,
               xHit, xMiss, xPa, xFf, xCf);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R10 R13 reset state
    chk("R10 victim after reset", 32'(victimIdx), 0);
    chk("R13 idle after reset", {31'd0, rspValid}, 0);
    chk("R9 missAddr after reset", missAddr, 0);

    look("R9 empty table", 32'h1234_5678, 3, 0, 1, 0, 1, 0, 0, 0);
    chk("R9 held miss address", missAddr, 32'h1234_5678);

    wr(0, 0, 20'h12345, 0, 0, 0, 3, 0, 5, 0, 0, 1, 20'hABCDE);
    look("R2 4K hit", 32'h1234_5678, 3, 0, 1, 1, 0, 32'hABCD_E678, 0, 0);
    chk("R6 group", 32'(rspGroup), 5);
    look("R5 asid mismatch", 32'h1234_5678, 4, 0, 1, 0, 1, 0, 0, 0);

    wr(0, 31, 20'h20000, 1, 0, 0, 0, 1, 2, 0, 0, 1, 20'h40000);
    look("R1 R5 shared 16K at index 31", 32'h2000_3ABC, 9, 0, 1, 1, 0, 32'h4000_3ABC, 0, 0);
    wr(0, 5, 20'h30000, 2, 0, 0, 1, 0, 1, 0, 0, 1, 20'h50000);
    look("R2 512K", 32'h3007_1234, 1, 0, 1, 1, 0, 32'h5007_1234, 0, 0);
    wr(0, 6, 20'h08000, 3, 0, 0, 1, 0, 1, 0, 0, 1, 20'h60000);
    look("R2 8M top", 32'h087F_FFFC, 1, 0, 1, 1, 0, 32'h607F_FFFC, 0, 0);
    look("R2 8M beyond", 32'h0880_0000, 1, 0, 1, 0, 1, 0, 0, 0);

    wr(0, 7, 20'h40001, 0, 1, 4'b0101, 1, 0, 1, 0, 0, 1, 20'h70001);
    look("R3 subpage 0", 32'h4000_1000, 1, 0, 1, 1, 0, 32'h7000_1000, 0, 0);
    look("R3 subpage 1 invalid", 32'h4000_1400, 1, 0, 1, 0, 1, 0, 0, 0);
    look("R3 subpage 2", 32'h4000_1804, 1, 0, 1, 1, 0, 32'h7000_1804, 0, 0);

    look("R4 bypass", 32'hDEAD_BEEF, 1, 2, 0, 0, 0, 32'hDEAD_BEEF, 0, 0);
    chk("R4 missAddr untouched", missAddr, 32'h4000_1400);

    wr(0, 8, 20'h50000, 0, 0, 0, 1, 0, 1, 1, 0, 1, 20'h80000);
    wr(0, 9, 20'h50001, 0, 0, 0, 1, 0, 1, 0, 1, 1, 20'h80001);
    look("R7 fetch no-exec", 32'h5000_0010, 1, 2, 1, 1, 0, 0, 1, 0);
    look("R7 load no-exec", 32'h5000_0010, 1, 0, 1, 1, 0, 32'h8000_0010, 0, 0);
    look("R7 fetch guarded", 32'h5000_1020, 1, 2, 1, 1, 0, 0, 1, 0);

    wr(0, 10, 20'h50002, 0, 0, 0, 1, 0, 1, 0, 0, 0, 20'h80002);
    look("R8 store unchanged", 32'h5000_2030, 1, 1, 1, 1, 0, 0, 0, 1);
    look("R8 load unchanged", 32'h5000_2030, 1, 0, 1, 1, 0, 32'h8000_2030, 0, 0);
    look("R8 store changed", 32'h1234_5000, 3, 1, 1, 1, 0, 32'hABCD_E000, 0, 0);

    wr(0, 12, 20'h12345, 0, 0, 0, 3, 0, 9, 0, 0, 1, 20'h11111);
    look("R12 lowest wins", 32'h1234_5678, 3, 0, 1, 1, 0, 32'hABCD_E678, 0, 0);
    chk("R12 multi flag", {31'd0, rspMultiHit}, 1);

    // R11 single invalidate, and load blocked by concurrent invalidate
    @(negedge clk);
    invOne = 1; invIndex = 0; wrEn = 1; wrIndex = 20; wrVpn = 20'h77777; wrPsize = 0;
    wrSubEn = 0; wrAsid = 1; wrShared = 0; wrPpn = 20'h77777; wrChanged = 1;
    @(negedge clk);
    invOne = 0; wrEn = 0;
    look("R11 after single invalidate", 32'h1234_5678, 3, 0, 1, 1, 0, 32'h1111_1678, 0, 0);
    chk("R11 multi cleared", {31'd0, rspMultiHit}, 0);
    look("R11 load lost to invalidate", 32'h7777_7000, 1, 0, 1, 0, 1, 0, 0, 0);

    // R10 victim stepping and wrap
    for (int i = 0; i < 3; i++) wr(1, 0, 20'h90000 + 20'(i), 0, 0, 0, 2, 0, 0, 0, 0, 1, 20'hA0000 + 20'(i));
    chk("R10 victim after three", 32'(victimIdx), 3);
    look("R10 victim slot 1", 32'h9000_1004, 2, 0, 1, 1, 0, 32'hA000_1004, 0, 0);
    wr(0, 0, 20'h90000, 0, 0, 0, 2, 0, 0, 0, 0, 1, 20'hA0000);
    chk("R10 explicit keeps victim", 32'(victimIdx), 3);
    for (int i = 0; i < 29; i++) wr(1, 0, 20'hB0000 + 20'(i), 0, 0, 0, 2, 0, 0, 0, 0, 1, 20'hC0000);
    chk("R10 victim wrap", 32'(victimIdx), 0);

    @(negedge clk); invAll = 1;
    @(negedge clk); invAll = 0;
    look("R11 full invalidate", 32'hB000_0000, 2, 0, 1, 0, 1, 0, 0, 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule